// File: doc/BRIEF.md
# OTG Host Role Negotiation Controller

This block lets a dual-role USB port that powered up as the peripheral (B side) take over the host role during a session. Software asks for the role change by setting a host-request bit. It may set the bit in the same cycle as it starts a session, or at any later point while the session is open. The controller does not act on the request straight away. It waits for the bus to enter suspend, which is the idle J state held for a parameterised number of cycles. The bit must still be set at that moment.

Once that condition is met, the controller switches the port to host mode and removes the local D+ pull-up. It then waits for the far end to attach its own pull-up. When that pull-up appears, the controller raises a one-cycle connect interrupt and asserts bus reset on the next clock edge without any help from software. Bus reset stays asserted until software releases it. If the far end never attaches within a timeout, the port restores its pull-up, goes back to device mode and reports a negotiation failure. Clearing the session at any point cancels the whole process.

With the ID input low, starting a session puts the port straight into host mode. No negotiation is involved in that case.

Top module: `otg_role_switch`

## Requirements
- R1: After reset, `session`, `host_mode`, `pullup_en`, `hreq`, `bus_reset`, `conn_irq` and `neg_fail` are all 0.
- R2: When `sess_set` is high with no session open, the next edge opens a session. With `id_pin`=1 the port enters device mode (`pullup_en`=1, `host_mode`=0). With `id_pin`=0 it enters host mode (`host_mode`=1, `pullup_en`=0).
- R3: `hreq_set` sets `hreq` on the next edge if a session is open or `sess_set` is high in the same cycle. Otherwise it is ignored and `hreq` stays 0.
- R4: Suspend entry is the `SUSP_CYCLES`-th consecutive clock edge with `line_j`=1 during a session. In device mode, negotiation starts at that edge only if `hreq` was already 1 before it. A shorter J run, or a request set in that same cycle, leaves the port in device mode.
- R5: When negotiation starts, `host_mode` becomes 1 and `pullup_en` becomes 0 at that same edge.
- R6: While the port waits for the far end, the first edge with `remote_pu`=1 raises `conn_irq` for exactly one cycle and sets `bus_reset`=1 at that same edge.
- R7: `bus_reset` stays 1 until an edge with `rst_clr`=1. After that edge `bus_reset` is 0 and `host_mode` stays 1.
- R8: If `remote_pu` is still 0 at the `CONN_TIMEOUT`-th edge after negotiation started, that edge returns the port to device mode (`pullup_en`=1, `host_mode`=0). It also pulses `neg_fail` for one cycle and clears `hreq`.
- R9: `sess_clr` at an edge closes the session from any state and clears `hreq`. It takes priority over suspend entry, remote connect and timeout in the same cycle, so `conn_irq` and `neg_fail` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_pin | input | 1 | Cable ID: 1 = default peripheral, 0 = default host |
| sess_set | input | 1 | Software session-start request (one-cycle strobe) |
| sess_clr | input | 1 | Software session-end request (one-cycle strobe) |
| hreq_set | input | 1 | Software host-role request (one-cycle strobe) |
| rst_clr | input | 1 | Software release of bus reset (one-cycle strobe) |
| line_j | input | 1 | Bus line state is idle J |
| remote_pu | input | 1 | Far-end D+ pull-up detected |
| session | output | 1 | Session open |
| host_mode | output | 1 | Port acting as host |
| pullup_en | output | 1 | Local D+ pull-up enabled |
| hreq | output | 1 | Pending host-role request bit |
| bus_reset | output | 1 | Bus reset driven |
| conn_irq | output | 1 | Connect interrupt, one-cycle pulse |
| neg_fail | output | 1 | Negotiation timeout, one-cycle pulse |

## Verification
A session clear can arrive in the same cycle as a role-changing event: suspend entry, the far-end connect, or the timeout. The bench provokes this in two ways. It strobes `sess_clr` at exactly the `SUSP_CYCLES`-th J edge. It also raises `sess_clr` together with `remote_pu` while the port is waiting for the far end. In both cases the bench expects the port to be idle afterwards, with `hreq` at 0 and no interrupt. A second collision sets the host request in the very cycle suspend is reached; the port must stay in device mode. Randomised J-run lengths around the threshold, with and without a pending request, are judged by a bench function that gives the expected role.

// File: rtl/otg_rs_pkg.sv
package otg_rs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE     = 3'd0,
    RS_DEV      = 3'd1,
    RS_HOST_DEF = 3'd2,
    RS_NEG_WAIT = 3'd3,
    RS_NEG_RST  = 3'd4,
    RS_HOST     = 3'd5
  } rs_state_t;
endpackage

// File: rtl/otg_run_timer.sv
// Saturating run counter: hit fires in the LIMIT-th consecutive enabled cycle.
module otg_run_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (en && (cnt_q != LIM)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = en && !clr && (cnt_q == LIM_M1);
endmodule

// File: rtl/otg_neg_fsm.sv
module otg_neg_fsm
  import otg_rs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      id_pin,
  input  logic      sess_set,
  input  logic      sess_clr,
  input  logic      hreq_set,
  input  logic      rst_clr,
  input  logic      remote_pu,
  input  logic      susp_hit,
  input  logic      tmo_hit,
  output rs_state_t state_o,
  output logic      hreq_o,
  output logic      conn_irq_o,
  output logic      neg_fail_o
);
  rs_state_t st_q, st_d;
  logic      hreq_q, hreq_d;
  logic      irq_q, irq_d;
  logic      fail_q, fail_d;

  always_comb begin
    st_d   = st_q;
    hreq_d = hreq_q;
    irq_d  = 1'b0;
    fail_d = 1'b0;
    if (hreq_set && ((st_q != RS_IDLE) || sess_set)) hreq_d = 1'b1;
    case (st_q)
      RS_IDLE:     if (sess_set) st_d = id_pin ? RS_DEV : RS_HOST_DEF;
      RS_DEV:      if (susp_hit && hreq_q) st_d = RS_NEG_WAIT;
      RS_NEG_WAIT: begin
        if (remote_pu) begin
          st_d  = RS_NEG_RST;
          irq_d = 1'b1;
        end else if (tmo_hit) begin
          st_d   = RS_DEV;
          fail_d = 1'b1;
          hreq_d = 1'b0;
        end
      end
      RS_NEG_RST:  if (rst_clr) st_d = RS_HOST;
      default:     ;
    endcase
    // session teardown overrides every other event
    if (sess_clr) begin
      st_d   = RS_IDLE;
      hreq_d = 1'b0;
      irq_d  = 1'b0;
      fail_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      hreq_q <= 1'b0;
      irq_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hreq_q <= hreq_d;
      irq_q  <= irq_d;
      fail_q <= fail_d;
    end
  end

  assign state_o    = st_q;
  assign hreq_o     = hreq_q;
  assign conn_irq_o = irq_q;
  assign neg_fail_o = fail_q;
endmodule

// File: rtl/otg_role_switch.sv
module otg_role_switch
  import otg_rs_pkg::*;
#(
  parameter int SUSP_CYCLES  = 3000,
  parameter int CONN_TIMEOUT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic id_pin,
  input  logic sess_set,
  input  logic sess_clr,
  input  logic hreq_set,
  input  logic rst_clr,
  input  logic line_j,
  input  logic remote_pu,
  output logic session,
  output logic host_mode,
  output logic pullup_en,
  output logic hreq,
  output logic bus_reset,
  output logic conn_irq,
  output logic neg_fail
);
  rs_state_t state;
  logic      susp_hit, tmo_hit;
  logic      j_run, in_wait;

  assign j_run   = line_j && session;
  assign in_wait = (state == RS_NEG_WAIT);

  otg_run_timer #(.LIMIT(SUSP_CYCLES)) susp_tmr_i (
    .clk(clk), .rst_n(rst_n), .en(j_run), .clr(!j_run), .hit(susp_hit)
  );

  otg_run_timer #(.LIMIT(CONN_TIMEOUT)) conn_tmr_i (
    .clk(clk), .rst_n(rst_n), .en(in_wait), .clr(!in_wait), .hit(tmo_hit)
  );

  otg_neg_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .id_pin(id_pin), .sess_set(sess_set),
    .sess_clr(sess_clr), .hreq_set(hreq_set), .rst_clr(rst_clr),
    .remote_pu(remote_pu), .susp_hit(susp_hit), .tmo_hit(tmo_hit),
    .state_o(state), .hreq_o(hreq), .conn_irq_o(conn_irq),
    .neg_fail_o(neg_fail)
  );

  assign session   = (state != RS_IDLE);
  assign host_mode = (state == RS_HOST_DEF) || (state == RS_NEG_WAIT) ||
                     (state == RS_NEG_RST)  || (state == RS_HOST);
  assign pullup_en = (state == RS_DEV);
  assign bus_reset = (state == RS_NEG_RST);
endmodule

// File: rtl/otg_role_switch_chk.sv
module otg_role_switch_chk (
  input logic clk,
  input logic rst_n,
  input logic id_pin,
  input logic sess_set,
  input logic sess_clr,
  input logic rst_clr,
  input logic session,
  input logic host_mode,
  input logic pullup_en,
  input logic hreq,
  input logic bus_reset,
  input logic conn_irq,
  input logic neg_fail
);
  p_start_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_set && !session && !sess_clr && id_pin) |=> (pullup_en && !host_mode));

  p_no_req_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !session |-> !hreq);

  p_pullup_off_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |-> !pullup_en);

  p_irq_with_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conn_irq |-> bus_reset);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conn_irq |=> !conn_irq);

  p_reset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !rst_clr && !sess_clr) |=> bus_reset);

  p_fail_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    neg_fail |-> (pullup_en && !host_mode && !hreq));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sess_clr |=> (!session && !hreq && !conn_irq && !neg_fail));
endmodule

bind otg_role_switch otg_role_switch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .id_pin(id_pin), .sess_set(sess_set),
  .sess_clr(sess_clr), .rst_clr(rst_clr), .session(session),
  .host_mode(host_mode), .pullup_en(pullup_en), .hreq(hreq),
  .bus_reset(bus_reset), .conn_irq(conn_irq), .neg_fail(neg_fail)
);

// File: tb/otg_role_switch_tb.sv
module otg_role_switch_tb_top;
  localparam int SUSP = 20;
  localparam int TMO  = 40;

  logic clk, rst_n;
  logic id_pin, sess_set, sess_clr, hreq_set, rst_clr, line_j, remote_pu;
  logic session, host_mode, pullup_en, hreq, bus_reset, conn_irq, neg_fail;
  int   n_run, n_fail;
  bit   done;

  otg_role_switch #(.SUSP_CYCLES(SUSP), .CONN_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_pin(id_pin), .sess_set(sess_set),
    .sess_clr(sess_clr), .hreq_set(hreq_set), .rst_clr(rst_clr),
    .line_j(line_j), .remote_pu(remote_pu), .session(session),
    .host_mode(host_mode), .pullup_en(pullup_en), .hreq(hreq),
    .bus_reset(bus_reset), .conn_irq(conn_irq), .neg_fail(neg_fail)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected role after a J run of length len with request state rq
  function automatic bit exp_host(bit rq, int len);
    return rq && (len >= SUSP);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic strobe_sess(bit id, bit with_req);
    id_pin = id; sess_set = 1'b1; hreq_set = with_req;
    tick();
    sess_set = 1'b0; hreq_set = 1'b0;
  endtask

  task automatic end_sess();
    sess_clr = 1'b1; line_j = 1'b0; remote_pu = 1'b0;
    tick();
    sess_clr = 1'b0;
  endtask

  task automatic go_suspend();
    line_j = 1'b1;
    repeat (SUSP) tick();
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0;
    void'($urandom(32'd1234));
    id_pin = 1'b1; sess_set = 0; sess_clr = 0; hreq_set = 0;
    rst_clr = 0; line_j = 0; remote_pu = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1", "session", session, 0);
    chk("R1", "host_mode", host_mode, 0);
    chk("R1", "pullup_en", pullup_en, 0);
    chk("R1", "bus_reset", bus_reset, 0);
    chk("R1", "irq/fail", conn_irq | neg_fail | hreq, 0);

    // R3 request without session ignored
    hreq_set = 1'b1; tick(); hreq_set = 1'b0;
    chk("R3", "hreq no session", hreq, 0);

    // R2 device start
    strobe_sess(1'b1, 1'b0);
    chk("R2", "pullup dev", pullup_en, 1);
    chk("R2", "host dev", host_mode, 0);

    // R4 suspend without request: no change
    go_suspend(); line_j = 1'b0; tick();
    chk("R4", "no req stays dev", host_mode, 0);

    // R3 request during session
    hreq_set = 1'b1; tick(); hreq_set = 1'b0;
    chk("R3", "hreq in session", hreq, 1);

    // R4 short J run
    line_j = 1'b1; repeat (SUSP - 1) tick();
    chk("R4", "short run", host_mode, 0);
    line_j = 1'b0; tick();
    chk("R4", "after drop", host_mode, 0);

    // R4/R5 full run
    line_j = 1'b1; repeat (SUSP - 1) tick();
    chk("R4", "one short", host_mode, 0);
    tick();
    chk("R5", "host on", host_mode, 1);
    chk("R5", "pullup off", pullup_en, 0);
    line_j = 1'b0;
    repeat (5) tick();
    // R6 connect
    remote_pu = 1'b1; tick(); remote_pu = 1'b0;
    chk("R6", "conn_irq", conn_irq, 1);
    chk("R6", "bus_reset", bus_reset, 1);
    tick();
    chk("R6", "irq one cycle", conn_irq, 0);
    repeat (10) tick();
    chk("R7", "reset held", bus_reset, 1);
    rst_clr = 1'b1; tick(); rst_clr = 1'b0;
    chk("R7", "reset released", bus_reset, 0);
    chk("R7", "still host", host_mode, 1);

    // R9 abort from host
    end_sess();
    chk("R9", "session off", session, 0);
    chk("R9", "hreq off", hreq, 0);

    // R3 request with start, R8 timeout
    strobe_sess(1'b1, 1'b1);
    chk("R3", "hreq with start", hreq, 1);
    go_suspend();
    chk("R5", "host on (tmo run)", host_mode, 1);
    repeat (TMO - 1) tick();
    chk("R8", "before timeout", host_mode, 1);
    tick();
    chk("R8", "back to dev", host_mode, 0);
    chk("R8", "pullup restored", pullup_en, 1);
    chk("R8", "neg_fail", neg_fail, 1);
    chk("R8", "hreq cleared", hreq, 0);
    tick();
    chk("R8", "fail one cycle", neg_fail, 0);
    end_sess();

    // R2 A side start
    strobe_sess(1'b0, 1'b0);
    chk("R2", "host default", host_mode, 1);
    chk("R2", "pullup off", pullup_en, 0);
    end_sess();

    // R9 clear at suspend entry edge
    strobe_sess(1'b1, 1'b1);
    line_j = 1'b1; repeat (SUSP - 1) tick();
    sess_clr = 1'b1; tick(); sess_clr = 1'b0; line_j = 1'b0;
    chk("R9", "clr beats suspend", host_mode | session, 0);
    chk("R9", "hreq after clr", hreq, 0);

    // R9 clear with remote connect
    strobe_sess(1'b1, 1'b1);
    go_suspend(); line_j = 1'b0;
    remote_pu = 1'b1; sess_clr = 1'b1; tick();
    remote_pu = 1'b0; sess_clr = 1'b0;
    chk("R9", "no irq on clr", conn_irq, 0);
    chk("R9", "no reset on clr", bus_reset | session, 0);

    // R4 request set at the suspend entry cycle
    strobe_sess(1'b1, 1'b0);
    line_j = 1'b1; repeat (SUSP - 1) tick();
    hreq_set = 1'b1; tick(); hreq_set = 1'b0;
    chk("R4", "late req not acted", host_mode, 0);
    chk("R4", "late req latched", hreq, 1);
    end_sess();

    // R4 random J runs
    for (int it = 0; it < 24; it++) begin
      bit rq;
      int len;
      rq  = 1'($urandom_range(0, 1));
      len = int'($urandom_range(1, 2 * SUSP));
      strobe_sess(1'b1, rq);
      line_j = 1'b1; repeat (len) tick();
      line_j = 1'b0; tick();
      chk("R4", "random run", host_mode, exp_host(rq, len));
      end_sess();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule